// File: doc/BRIEF.md
# Block Copy DMA Engine

This engine moves a run of bytes from one place in a 15-bit address space to another over a shared byte-wide bus. Software programs it through eight byte-wide register slots: a source address, a destination address, a source bank number and a 12-bit count. Writing the low count byte is the trigger. The engine then takes the bus and alternates one read cycle with one write cycle for each byte until the whole run has moved.

The address registers are the live pointers. Software reading them after a copy sees where each pointer stopped, so two back-to-back copies can be chained without reloading them. The top bit of the source high byte sends reads into a banked ROM window. In that case the bus address is the bank number placed above the 15 source bits, and a separate qualifier marks the access as a ROM access. The destination can be held still so that a whole run lands on one address, for example a data port. A stall input lets a higher-priority requester hold the engine between bus cycles.

Top module: `dma_mover`

## Requirements
- R1: After reset, the source, destination and bank slots (offsets 0, 1, 2, 3 and 6) read 00h. `busy` and `bus_req` are low.
- R2: While idle, a write to offset 4 starts a copy of {offset-5 bits [3:0], written byte} + 1 bytes. A value of 0 moves one byte and a value of FFFh moves 4096 bytes. `busy` is high in the cycle after that write.
- R3: Each byte is one read cycle (`bus_req`=1, `bus_we`=0) followed by one write cycle (`bus_we`=1). With no stall, a copy of N bytes keeps `busy` high for exactly 2N cycles.
- R4: The byte placed on `bus_wdata` in a write cycle is the `bus_rdata` value sampled in the preceding accepted read cycle. Reads use the source pointer and writes use the destination pointer.
- R5: Both pointers step by one after every byte written and keep their final values. Source 5000h, destination 6000h and count 0FFh end at 5100h and 6100h. The low bytes read back at offsets 0 and 2. The high bytes read back at offsets 1 and 3, with bits [6:0] holding address bits [14:8].
- R6: When bit 4 of offset 5 is set, every write of the copy goes to the starting destination address, and the destination pointer keeps that value.
- R7: When bit 7 of offset 1 is set, read addresses are {bank from offset 6, source[14:0]} with `bus_rom` high. When it is clear, the upper address bits are zero and `bus_rom` is low. Writes never assert `bus_rom` and never use the bank. Bit 7 of offset 3 is stored and read back, but it has no effect on the copy.
- R8: Offsets 4, 5 and 7 read FFh. The value written to offset 5 stays in place after a copy, so a later write to offset 4 alone reuses it.
- R9: While `bus_stall` is high, the engine holds its bus command (address, direction and write data) unchanged and does not advance. The result of the copy is the same as without stalls.
- R10: Register writes made while `busy` is high are ignored, including a write to offset 4. No second copy is started by them.
- R11: Pointers wrap from 7FFFh to 0000h within 15 bits, and the bank-select flag in bit 7 of offset 1 is kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wr_en | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register slot offset |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data (combinational) |
| busy | output | 1 | A copy is in progress |
| bus_req | output | 1 | Bus cycle requested this clock |
| bus_we | output | 1 | 1 = write cycle, 0 = read cycle |
| bus_rom | output | 1 | Read targets the banked ROM window |
| bus_addr | output | ADDR_W+BANK_W | Bus address |
| bus_wdata | output | 8 | Write data |
| bus_rdata | input | 8 | Read data, valid in the read cycle |
| bus_stall | input | 1 | Hold the current bus cycle |

## Verification
The bench targets the single-byte and full 4096-byte counts, where an off-by-one in the count logic shows up as one byte too many or too few, or as a copy that never ends. It wraps both pointers past 7FFFh. A design that carries into bit 15 would either drop the bank flag or send writes outside the space. Hold-destination runs catch a pointer that keeps stepping. Banked reads catch a missing bank field or a missing ROM qualifier, and the pattern memory detects either as corrupted data. Irregular stalls catch an engine that drops or repeats a byte. Writes poked in mid-copy catch a trigger that re-arms, or pointers that are overwritten while a copy runs.

// File: rtl/dma_mover_pkg.sv
// Shared definitions for the block copy DMA engine: register slot offsets,
// control bit positions and the transfer state encoding.
package dma_mover_pkg;

    // Register slot offsets; writing RA_CNT_LO is the start trigger.
    localparam logic [2:0] RA_SRC_LO = 3'd0;
    localparam logic [2:0] RA_SRC_HI = 3'd1;
    localparam logic [2:0] RA_DST_LO = 3'd2;
    localparam logic [2:0] RA_DST_HI = 3'd3;
    localparam logic [2:0] RA_CNT_LO = 3'd4;
    localparam logic [2:0] RA_CNT_HI = 3'd5;
    localparam logic [2:0] RA_BANK   = 3'd6;

    // Bit positions inside the high-byte slots.
    localparam int HOLD_BIT = 4;   // count high slot: keep destination fixed
    localparam int FLAG_BIT = 7;   // source high slot: read from banked ROM

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_READ  = 2'd1,
        ST_WRITE = 2'd2
    } xfer_state_e;

endpackage

// File: rtl/dma_mover_regs.sv
// Register file of the copy engine. It holds the live source and
// destination pointers, the bank number, the retained count high bits and
// the hold flag. It decodes the start trigger and steps the pointers once
// per written byte.
// Assumes 9 <= ADDR_W <= 15, 9 <= LEN_W <= 12 and 1 <= BANK_W <= 8.
module dma_mover_regs
    import dma_mover_pkg::*;
#(
    parameter int ADDR_W = 15,
    parameter int BANK_W = 7,
    parameter int LEN_W  = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [2:0]        addr,
    input  logic [7:0]        wdata,
    input  logic              busy,
    input  logic              step,
    output logic [7:0]        rdata,
    output logic [ADDR_W-1:0] src_addr,
    output logic              src_banked,
    output logic [ADDR_W-1:0] dst_addr,
    output logic              dst_fixed,
    output logic [BANK_W-1:0] bank,
    output logic              start,
    output logic [LEN_W-1:0]  start_len
);

    localparam int HI_W     = ADDR_W - 8;
    localparam int LEN_HI_W = LEN_W - 8;
    localparam logic [ADDR_W-1:0] ONE_A = {{(ADDR_W-1){1'b0}}, 1'b1};

    logic [ADDR_W-1:0]   src_q;
    logic [ADDR_W-1:0]   dst_q;
    logic                src_flag_q;
    logic                dst_spare_q;
    logic                hold_q;
    logic [LEN_HI_W-1:0] len_hi_q;
    logic [BANK_W-1:0]   bank_q;
    logic                wr_ok;

    // Software writes are accepted only while no copy runs.
    assign wr_ok = wr_en && !busy;

    // Register updates: software writes while idle, pointer steps while busy.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            src_q       <= '0;
            dst_q       <= '0;
            src_flag_q  <= 1'b0;
            dst_spare_q <= 1'b0;
            hold_q      <= 1'b0;
            len_hi_q    <= '0;
            bank_q      <= '0;
        end else begin
            if (wr_ok) begin
                case (addr)
                    RA_SRC_LO: src_q[7:0] <= wdata;
                    RA_SRC_HI: begin
                        src_q[ADDR_W-1:8] <= wdata[HI_W-1:0];
                        src_flag_q        <= wdata[FLAG_BIT];
                    end
                    RA_DST_LO: dst_q[7:0] <= wdata;
                    RA_DST_HI: begin
                        dst_q[ADDR_W-1:8] <= wdata[HI_W-1:0];
                        dst_spare_q       <= wdata[FLAG_BIT];
                    end
                    RA_CNT_HI: begin
                        len_hi_q <= wdata[LEN_HI_W-1:0];
                        hold_q   <= wdata[HOLD_BIT];
                    end
                    RA_BANK:   bank_q <= wdata[BANK_W-1:0];
                    default:   ;
                endcase
            end
            if (step) begin
                src_q <= src_q + ONE_A;
                if (!hold_q) begin
                    dst_q <= dst_q + ONE_A;
                end
            end
        end
    end

    // Read mux: count slots and unused offsets return all ones.
    always_comb begin
        rdata = 8'hFF;
        case (addr)
            RA_SRC_LO: rdata = src_q[7:0];
            RA_SRC_HI: begin
                rdata                = 8'h00;
                rdata[HI_W-1:0]      = src_q[ADDR_W-1:8];
                rdata[FLAG_BIT]      = src_flag_q;
            end
            RA_DST_LO: rdata = dst_q[7:0];
            RA_DST_HI: begin
                rdata                = 8'h00;
                rdata[HI_W-1:0]      = dst_q[ADDR_W-1:8];
                rdata[FLAG_BIT]      = dst_spare_q;
            end
            RA_BANK: begin
                rdata               = 8'h00;
                rdata[BANK_W-1:0]   = bank_q;
            end
            default: rdata = 8'hFF;
        endcase
    end

    assign start      = wr_ok && (addr == RA_CNT_LO);
    assign start_len  = {len_hi_q, wdata};
    assign src_addr   = src_q;
    assign src_banked = src_flag_q;
    assign dst_addr   = dst_q;
    assign dst_fixed  = hold_q;
    assign bank       = bank_q;

endmodule

// File: rtl/dma_mover_ctrl.sv
// Bus master sequencer. It alternates read and write phases, counts the
// bytes that remain and freezes whenever the stall input is high.
// Assumes start only arrives while idle; the register file guarantees this.
module dma_mover_ctrl
    import dma_mover_pkg::*;
#(
    parameter int LEN_W = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [LEN_W-1:0] start_len,
    input  logic             stall,
    output logic             busy,
    output logic             rd_phase,
    output logic             wr_phase,
    output logic             capture,
    output logic             step
);

    localparam logic [LEN_W-1:0] ONE_L = {{(LEN_W-1){1'b0}}, 1'b1};

    xfer_state_e      state_q;
    logic [LEN_W-1:0] left_q;

    // Phase sequencing and count of bytes that remain after the current one.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            left_q  <= '0;
        end else begin
            case (state_q)
                ST_IDLE: begin
                    if (start) begin
                        left_q  <= start_len;
                        state_q <= ST_READ;
                    end
                end
                ST_READ: begin
                    if (!stall) begin
                        state_q <= ST_WRITE;
                    end
                end
                ST_WRITE: begin
                    if (!stall) begin
                        if (left_q == '0) begin
                            state_q <= ST_IDLE;
                        end else begin
                            left_q  <= left_q - ONE_L;
                            state_q <= ST_READ;
                        end
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    assign rd_phase = (state_q == ST_READ);
    assign wr_phase = (state_q == ST_WRITE);
    assign busy     = rd_phase || wr_phase;
    assign capture  = rd_phase && !stall;
    assign step     = wr_phase && !stall;

endmodule

// File: rtl/dma_mover_bus.sv
// Bus front end. It holds the byte read in the read phase and forms the
// address for each phase: a flat or banked source on reads and a flat
// destination on writes.
// Assumes read data is valid in the same cycle as the read request.
module dma_mover_bus #(
    parameter int ADDR_W = 15,
    parameter int BANK_W = 7
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     rd_phase,
    input  logic                     wr_phase,
    input  logic                     capture,
    input  logic [ADDR_W-1:0]        src_addr,
    input  logic                     src_banked,
    input  logic [ADDR_W-1:0]        dst_addr,
    input  logic [BANK_W-1:0]        bank,
    input  logic [7:0]               mem_rdata,
    output logic                     bus_req,
    output logic                     bus_we,
    output logic                     bus_rom,
    output logic [ADDR_W+BANK_W-1:0] bus_addr,
    output logic [7:0]               bus_wdata
);

    localparam int BUS_AW = ADDR_W + BANK_W;

    logic [7:0]        data_q;
    logic [BUS_AW-1:0] src_full;

    // Byte holding register: loaded by each accepted read.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            data_q <= 8'h00;
        end else if (capture) begin
            data_q <= mem_rdata;
        end
    end

    // Source address extension: bank bits on top, or zeros.
    always_comb begin
        src_full = {{BANK_W{1'b0}}, src_addr};
        if (src_banked) begin
            src_full = {bank, src_addr};
        end
    end

    // Bus command for the current phase.
    always_comb begin
        bus_addr = '0;
        if (rd_phase) begin
            bus_addr = src_full;
        end else if (wr_phase) begin
            bus_addr = {{BANK_W{1'b0}}, dst_addr};
        end
    end

    assign bus_req   = rd_phase || wr_phase;
    assign bus_we    = wr_phase;
    assign bus_rom   = rd_phase && src_banked;
    assign bus_wdata = data_q;

endmodule

// File: rtl/dma_mover.sv
// Block copy DMA engine top level. It joins the register file, the phase
// sequencer and the bus front end. One byte costs one read and one write
// cycle on the shared bus.
// Assumes a combinational register read port and same-cycle bus read data.
module dma_mover #(
    parameter int ADDR_W = 15,
    parameter int BANK_W = 7,
    parameter int LEN_W  = 12
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     reg_wr_en,
    input  logic [2:0]               reg_addr,
    input  logic [7:0]               reg_wdata,
    output logic [7:0]               reg_rdata,
    output logic                     busy,
    output logic                     bus_req,
    output logic                     bus_we,
    output logic                     bus_rom,
    output logic [ADDR_W+BANK_W-1:0] bus_addr,
    output logic [7:0]               bus_wdata,
    input  logic [7:0]               bus_rdata,
    input  logic                     bus_stall
);

    logic [ADDR_W-1:0] src_addr;
    logic [ADDR_W-1:0] dst_addr;
    logic              src_banked;
    logic              dst_fixed;
    logic [BANK_W-1:0] bank;
    logic              start;
    logic [LEN_W-1:0]  start_len;
    logic              rd_phase;
    logic              wr_phase;
    logic              capture;
    logic              step;

    dma_mover_regs #(
        .ADDR_W(ADDR_W),
        .BANK_W(BANK_W),
        .LEN_W (LEN_W)
    ) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (reg_wr_en),
        .addr      (reg_addr),
        .wdata     (reg_wdata),
        .busy      (busy),
        .step      (step),
        .rdata     (reg_rdata),
        .src_addr  (src_addr),
        .src_banked(src_banked),
        .dst_addr  (dst_addr),
        .dst_fixed (dst_fixed),
        .bank      (bank),
        .start     (start),
        .start_len (start_len)
    );

    dma_mover_ctrl #(
        .LEN_W(LEN_W)
    ) u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (start),
        .start_len(start_len),
        .stall    (bus_stall),
        .busy     (busy),
        .rd_phase (rd_phase),
        .wr_phase (wr_phase),
        .capture  (capture),
        .step     (step)
    );

    dma_mover_bus #(
        .ADDR_W(ADDR_W),
        .BANK_W(BANK_W)
    ) u_bus (
        .clk       (clk),
        .rst_n     (rst_n),
        .rd_phase  (rd_phase),
        .wr_phase  (wr_phase),
        .capture   (capture),
        .src_addr  (src_addr),
        .src_banked(src_banked),
        .dst_addr  (dst_addr),
        .bank      (bank),
        .mem_rdata (bus_rdata),
        .bus_req   (bus_req),
        .bus_we    (bus_we),
        .bus_rom   (bus_rom),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata)
    );

endmodule

// File: rtl/dma_mover_chk.sv
// Protocol checker for the copy engine, bound to the top level.
// It observes only port-level behaviour.
module dma_mover_chk
    import dma_mover_pkg::*;
#(
    parameter int BUS_AW = 22
) (
    input logic              clk,
    input logic              rst_n,
    input logic              reg_wr_en,
    input logic [2:0]        reg_addr,
    input logic              busy,
    input logic              bus_req,
    input logic              bus_we,
    input logic              bus_rom,
    input logic [BUS_AW-1:0] bus_addr,
    input logic [7:0]        bus_wdata,
    input logic [7:0]        bus_rdata,
    input logic              bus_stall
);

    AST_TRIGGER_STARTS: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr_en && reg_addr == RA_CNT_LO && !busy) |=> busy); // R2

    AST_READ_THEN_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req && !bus_we && !bus_stall) |=> (bus_req && bus_we)); // R3

    AST_DATA_FORWARD: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req && !bus_we && !bus_stall) |=> (bus_wdata == $past(bus_rdata))); // R4

    AST_ROM_ONLY_READS: assert property (@(posedge clk) disable iff (!rst_n)
        bus_rom |-> (bus_req && !bus_we)); // R7

    AST_STALL_FREEZES: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req && bus_stall) |=>
            (bus_req && $stable(bus_addr) && $stable(bus_we) && $stable(bus_wdata))); // R9

endmodule

bind dma_mover dma_mover_chk #(.BUS_AW(ADDR_W + BANK_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .reg_wr_en(reg_wr_en),
    .reg_addr (reg_addr),
    .busy     (busy),
    .bus_req  (bus_req),
    .bus_we   (bus_we),
    .bus_rom  (bus_rom),
    .bus_addr (bus_addr),
    .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata),
    .bus_stall(bus_stall)
);

// File: tb/test_dma_mover.sv
`timescale 1ns/1ps
module test_dma_mover;

    localparam int BUS_AW = 22;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              reg_wr_en = 1'b0;
    logic [2:0]        reg_addr = 3'd0;
    logic [7:0]        reg_wdata = 8'h00;
    logic [7:0]        reg_rdata;
    logic              busy;
    logic              bus_req;
    logic              bus_we;
    logic              bus_rom;
    logic [BUS_AW-1:0] bus_addr;
    logic [7:0]        bus_wdata;
    logic [7:0]        bus_rdata;
    logic              bus_stall = 1'b0;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    // monitor state
    int wr_total = 0, wr_bad = 0, busy_cyc = 0, stall_cyc = 0;
    int cur_base = 0;
    logic [14:0] cur_src = '0, cur_dst = '0;
    logic        cur_flag = 1'b0, cur_hold = 1'b0;
    logic [6:0]  cur_bank = '0;
    logic [3:0]  cur_lenhi = '0;

    always #2.5 clk = ~clk;

    dma_mover i_dma_mover (
        .clk(clk), .rst_n(rst_n), .reg_wr_en(reg_wr_en), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .busy(busy),
        .bus_req(bus_req), .bus_we(bus_we), .bus_rom(bus_rom),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .bus_stall(bus_stall)
    );

    // Pattern memory: every address (and the ROM qualifier) has a known byte.
    function automatic logic [7:0] pat(input logic [BUS_AW-1:0] a, input logic rom);
        return a[7:0] ^ a[15:8] ^ {a[21:16], 2'b00} ^ (rom ? 8'hA5 : 8'h00);
    endfunction

    assign bus_rdata = pat(bus_addr, bus_rom);

    // Vectors: {src[15:0], dst[15:0], cnt_hi, cnt_lo, bank}
    localparam logic [55:0] VEC [0:6] = '{
        {16'h5000, 16'h6000, 8'h00, 8'hFF, 8'h00},  // example run, R5
        {16'h0100, 16'h0200, 8'h00, 8'h00, 8'h00},  // single byte, R2
        {16'h8123, 16'h0300, 8'h00, 8'h0F, 8'h05},  // banked source, R7
        {16'h0010, 16'h0040, 8'h10, 8'h07, 8'h00},  // fixed destination, R6
        {16'h7FFC, 16'h7FFE, 8'h00, 8'h05, 8'h00},  // pointer wrap, R11
        {16'h0400, 16'h8500, 8'h00, 8'h03, 8'h00},  // dst bit7 no effect, R7
        {16'h1000, 16'h2000, 8'h0F, 8'hFF, 8'h00}   // 4096 bytes, R2
    };

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic reg_write(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk);
        reg_wr_en = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr_en = 1'b0;
    endtask

    task automatic reg_read(input logic [2:0] a, output logic [7:0] d);
        @(negedge clk);
        reg_addr = a;
        #1 d = reg_rdata;
    endtask

    // Write-cycle monitor, sampled 1 ns after the falling edge.
    always @(negedge clk) begin
        #1;
        if (busy) begin
            busy_cyc++;
            if (bus_stall) stall_cyc++;
        end
        if (bus_req && bus_we && !bus_stall) begin
            logic [14:0] es, ed;
            logic [BUS_AW-1:0] ea;
            es = cur_src + 15'(wr_total - cur_base);
            ed = cur_hold ? cur_dst : cur_dst + 15'(wr_total - cur_base);
            ea = cur_flag ? {cur_bank, es} : {7'd0, es};
            if (bus_addr != {7'd0, ed} || bus_wdata != pat(ea, cur_flag) || bus_rom)
                wr_bad++;
            wr_total++;
        end
    end

    // mode: 0 plain, 1 irregular stalls, 2 register pokes while busy
    task automatic do_xfer(input logic [15:0] src, input logic [15:0] dst,
                           input logic [7:0] hi, input logic [7:0] lo,
                           input logic [7:0] bnk, input bit write_hi,
                           input int mode, input string tag);
        int n, b0, w0, c0, s0, k;
        logic [7:0] rd;
        logic [14:0] sfin, dfin;
        reg_write(3'd6, bnk);
        reg_write(3'd0, src[7:0]);
        reg_write(3'd1, src[15:8]);
        reg_write(3'd2, dst[7:0]);
        reg_write(3'd3, dst[15:8]);
        if (write_hi) begin
            reg_write(3'd5, hi);
            cur_lenhi = hi[3:0];
            cur_hold  = hi[4];
        end
        cur_src = src[14:0]; cur_dst = dst[14:0];
        cur_flag = src[15]; cur_bank = bnk[6:0];
        n = {cur_lenhi, lo} + 1;
        cur_base = wr_total;
        w0 = wr_total; b0 = wr_bad; c0 = busy_cyc; s0 = stall_cyc;
        reg_write(3'd4, lo);
        k = 0;
        while (busy && k < 20000) begin
            if (mode == 1) bus_stall = (k % 3 == 1) || (k % 7 == 0);
            if (mode == 2) begin
                if (k == 2) begin reg_wr_en = 1'b1; reg_addr = 3'd0; reg_wdata = 8'hAA; end
                if (k == 3) begin reg_addr = 3'd4; reg_wdata = 8'h00; end
                if (k == 4) reg_wr_en = 1'b0;
            end
            k++;
            @(negedge clk);
        end
        bus_stall = 1'b0;
        reg_wr_en = 1'b0;
        check(wr_total - w0 == n, {tag, " R2 byte count"}, wr_total - w0, n);
        check(wr_bad == b0, {tag, " R4 R7 write addr/data"}, wr_bad - b0, 0);
        check(busy_cyc - c0 - (stall_cyc - s0) == 2 * n, {tag, " R3 R9 busy cycles"},
              busy_cyc - c0 - (stall_cyc - s0), 2 * n);
        sfin = cur_src + 15'(n);
        dfin = cur_hold ? cur_dst : cur_dst + 15'(n);
        reg_read(3'd0, rd); check(rd == sfin[7:0], {tag, " R5 src lo"}, rd, sfin[7:0]);
        reg_read(3'd1, rd); check(rd == {src[15], sfin[14:8]}, {tag, " R5 R11 src hi"}, rd, {src[15], sfin[14:8]});
        reg_read(3'd2, rd); check(rd == dfin[7:0], {tag, " R5 R6 dst lo"}, rd, dfin[7:0]);
        reg_read(3'd3, rd); check(rd == {dst[15], dfin[14:8]}, {tag, " R5 R6 dst hi"}, rd, {dst[15], dfin[14:8]});
        check(!busy, {tag, " R10 no restart"}, busy, 0);
    endtask

    initial begin
        #(5.0 * 150000);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog expired actual=hung expected=finished");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        logic [7:0] rd;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state
        check(!busy && !bus_req, "R1 idle after reset", {busy, bus_req}, 0);
        for (int a = 0; a < 8; a++) begin
            logic [7:0] e;
            e = (a == 4 || a == 5 || a == 7) ? 8'hFF : 8'h00;
            reg_read(3'(a), rd);
            check(rd == e, $sformatf("R1 R8 slot %0d readback", a), rd, e);
        end
        // table walk
        for (int v = 0; v < 7; v++) begin
            do_xfer(VEC[v][55:40], VEC[v][39:24], VEC[v][23:16], VEC[v][15:8],
                    VEC[v][7:0], 1'b1, 0, $sformatf("vec%0d", v));
        end
        // R8: count high is retained and count slots read FFh
        do_xfer(16'h0600, 16'h0A00, 8'h01, 8'h03, 8'h00, 1'b1, 0, "R8 first");
        reg_read(3'd5, rd); check(rd == 8'hFF, "R8 count hi reads FF", rd, 8'hFF);
        reg_read(3'd4, rd); check(rd == 8'hFF, "R8 count lo reads FF", rd, 8'hFF);
        do_xfer(16'h0600, 16'h0A00, 8'h00, 8'h00, 8'h00, 1'b0, 0, "R8 reuse hi");
        // R9: irregular stalls on a banked run
        do_xfer(16'h8200, 16'h0700, 8'h00, 8'h1F, 8'h33, 1'b1, 1, "R9 stalled");
        // R10: pokes while busy
        do_xfer(16'h0020, 16'h0800, 8'h00, 8'h07, 8'h00, 1'b1, 2, "R10 poke");
        @(negedge clk);
        check(!busy, "R10 trigger ignored while busy", busy, 0);
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule